// File: doc/BRIEF.md
# Weighted Round-Robin Associative Scheduler

This block decides, once per service slot, which virtual circuit may send a cell on a shared output link. Each circuit has a programmed weight and a ready flag. Bandwidth is shared among the ready circuits in proportion to their weights. The block keeps no list of queues. Instead, a free-running slot counter selects a weight-bit level in every slot. All entries of a small associative array are then searched in parallel for ready circuits whose stored weight has that bit set.

Weights are held with their bits reversed. The heaviest bit of a weight is therefore tested in the level that occurs most often. A weight of w then earns w slots out of every 2^W. When more than one entry matches, a rotating pointer takes the first match after the circuit that was granted last. A circuit that is not ready never matches. Its share therefore goes to the circuits that have cells to send.

The grant is combinational from the stored state, so it applies to the current slot. Ready flags, weights, the pointer and the counter all change at the clock edge that ends the slot.

Top module: `wrr_cam_sched`

## Requirements
- R1: A ready circuit with weight w that shares none of its levels with another ready circuit receives exactly w grants in any 2^W consecutive slots, with W = 4.
- R2: The level of a slot is the index of the lowest zero bit of the W-bit slot counter. In the slot where the counter is all ones, there is no level and no grant is made.
- R3: At level k, the bit of weight position W-1-k is examined. Position W-1 is the most significant bit of the value written on wrWeight.
- R4: A grant goes only to a circuit whose ready flag is set and whose weight bit at the current level is 1.
- R5: Among several matching circuits, the grant goes to the first match found by scanning upward, with wraparound, from the index after the last granted circuit. After reset, the scan starts at index 0.
- R6: If no circuit matches, grantValid is 0 for that slot, and the slot counter still advances by one.
- R7: readySet[i] sets the ready flag of circuit i at the next edge. readyClr[i] clears it only in a slot where circuit i is granted. If both apply to the same circuit in the same slot, readySet wins.
- R8: A weight written with wrEn is used from the next slot on.
- R9: Reset clears every weight and every ready flag, sets the slot counter to zero, and points the rotation at the last index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one service slot per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for a circuit weight |
| wrIdx | input | 3 | Circuit whose weight is written |
| wrWeight | input | 4 | Weight value, most significant bit first |
| readySet | input | 8 | Per-circuit arrival; sets the ready flag |
| readyClr | input | 8 | Per-circuit queue-empty flag; clears ready when that circuit is granted |
| grantValid | output | 1 | A circuit is granted in this slot |
| grantIdx | output | 3 | Index of the granted circuit |

## Verification
Several circuits share a level, and the bench checks that the rotation neither starves one of them nor repeats the last winner. A design with a fixed priority would give every shared slot to the lowest index. The all-ones counter slot must stay idle; a level decoder that wraps or defaults to level 0 would grant in it. The bench also sets and clears ready for the granted circuit in the same slot, and clears ready while that circuit is not granted. A design that lets the clear win would drop an arriving cell. A design that ignores the grant condition would silence a circuit that was never served. A weight written mid-stream must change the following slot. A reversal done the wrong way round would swap heavy and light shares, and the grant counts in the bandwidth check would expose it.

// File: rtl/wrr_pkg.sv
package wrr_pkg;
  parameter int NUM_VC   = 8;
  parameter int WEIGHT_W = 4;
  localparam int IDX_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1;

  typedef struct packed {
    logic                grantValid;
    logic [IDX_W-1:0]    grantIdx;
    logic [WEIGHT_W-1:0] levelOH;
  } ctrlStrobe_t;
endpackage

// File: rtl/wrr_cam_array.sv
module wrr_cam_array
  import wrr_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               wrEn,
  input  logic [IDX_W-1:0]                   wrIdx,
  input  logic [WEIGHT_W-1:0]                wrWeight,
  input  logic [NUM_VC-1:0]                  readySet,
  input  logic [NUM_VC-1:0]                  readyClr,
  input  ctrlStrobe_t                        strobe,
  output logic [NUM_VC-1:0]                  matchVec,
  output logic [NUM_VC-1:0]                  readyVec,
  output logic [NUM_VC-1:0][WEIGHT_W-1:0]    revWeight
);
  logic [WEIGHT_W-1:0] wrWeightRev;

  // bit-reverse the incoming weight: MSB lands at level 0
  for (genvar b = 0; b < WEIGHT_W; b++) begin : g_rev
    assign wrWeightRev[b] = wrWeight[WEIGHT_W-1-b];
  end

  for (genvar i = 0; i < NUM_VC; i++) begin : g_entry
    logic grantedHere;
    assign grantedHere = strobe.grantValid && (strobe.grantIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        revWeight[i] <= '0;
      end else if (wrEn && (wrIdx == IDX_W'(i))) begin
        revWeight[i] <= wrWeightRev;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        readyVec[i] <= 1'b0;
      end else if (readySet[i]) begin
        readyVec[i] <= 1'b1;
      end else if (grantedHere && readyClr[i]) begin
        readyVec[i] <= 1'b0;
      end
    end

    // associative compare against the one-hot level of this slot
    assign matchVec[i] = readyVec[i] && (|(revWeight[i] & strobe.levelOH));
  end
endmodule

// File: rtl/wrr_ctrl.sv
module wrr_ctrl
  import wrr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_VC-1:0]   matchVec,
  output ctrlStrobe_t         strobe,
  output logic [WEIGHT_W-1:0] slotCnt
);
  logic [IDX_W-1:0]    lastIdx;
  logic [WEIGHT_W-1:0] levelOH;
  logic                found;
  logic [IDX_W-1:0]    pickIdx;

  // lowest zero bit of the counter, one-hot; zero when counter is all ones
  assign levelOH = ~slotCnt & (slotCnt + WEIGHT_W'(1));

  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    for (int off = 1; off <= NUM_VC; off++) begin
      int cand;
      cand = (int'(lastIdx) + off) % NUM_VC;
      if (!found && matchVec[cand]) begin
        found   = 1'b1;
        pickIdx = IDX_W'(cand);
      end
    end
  end

  assign strobe.grantValid = found;
  assign strobe.grantIdx   = pickIdx;
  assign strobe.levelOH    = levelOH;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= '0;
      lastIdx <= IDX_W'(NUM_VC - 1);
    end else begin
      slotCnt <= slotCnt + WEIGHT_W'(1);
      if (found) lastIdx <= pickIdx;
    end
  end
endmodule

// File: rtl/wrr_cam_sched.sv
module wrr_cam_sched
  import wrr_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [WEIGHT_W-1:0] wrWeight,
  input  logic [NUM_VC-1:0]   readySet,
  input  logic [NUM_VC-1:0]   readyClr,
  output logic                grantValid,
  output logic [IDX_W-1:0]    grantIdx
);
  ctrlStrobe_t                     strobe;
  logic [NUM_VC-1:0]               matchVec;
  logic [NUM_VC-1:0]               readyVec;
  logic [NUM_VC-1:0][WEIGHT_W-1:0] revWeight;
  logic [WEIGHT_W-1:0]             slotCnt;

  wrr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .matchVec(matchVec),
    .strobe(strobe), .slotCnt(slotCnt)
  );

  wrr_cam_array u_array (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrWeight(wrWeight),
    .readySet(readySet), .readyClr(readyClr), .strobe(strobe),
    .matchVec(matchVec), .readyVec(readyVec), .revWeight(revWeight)
  );

  assign grantValid = strobe.grantValid;
  assign grantIdx   = strobe.grantIdx;
endmodule

// File: rtl/wrr_cam_sched_chk.sv
module wrr_cam_sched_chk
  import wrr_pkg::*;
(
  input logic                               clk,
  input logic                               rstN,
  input logic                               wrEn,
  input logic [IDX_W-1:0]                   wrIdx,
  input logic [WEIGHT_W-1:0]                wrWeight,
  input logic [NUM_VC-1:0]                  readySet,
  input logic [NUM_VC-1:0]                  readyClr,
  input logic                               grantValid,
  input logic [IDX_W-1:0]                   grantIdx,
  input logic [NUM_VC-1:0]                  readyVec,
  input logic [NUM_VC-1:0][WEIGHT_W-1:0]    revWeight,
  input logic [WEIGHT_W-1:0]                slotCnt
);
  function automatic logic [WEIGHT_W-1:0] flip(input logic [WEIGHT_W-1:0] v);
    for (int b = 0; b < WEIGHT_W; b++) flip[b] = v[WEIGHT_W-1-b];
  endfunction

  // R4: granted circuit is ready
  a_r4_grant_ready: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> readyVec[grantIdx]);

  // R2: all-ones counter slot is idle
  a_r2_idle_top_slot: assert property (@(posedge clk) disable iff (!rstN)
    (&slotCnt) |-> !grantValid);

  // R6: counter advances every slot
  a_r6_counter_advances: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> slotCnt == $past(slotCnt) + WEIGHT_W'(1));

  // R7: queue-empty clear on grant without arrival drops ready
  a_r7_clear_on_grant: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && readyClr[grantIdx] && !readySet[grantIdx]) |=> !readyVec[$past(grantIdx)]);

  // R7: arrival always sets ready
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (readySet != '0) |=> ((readyVec & $past(readySet)) == $past(readySet)));

  // R8: written weight stored reversed by next slot
  a_r8_weight_write: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> revWeight[$past(wrIdx)] == flip($past(wrWeight)));
endmodule

bind wrr_cam_sched wrr_cam_sched_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrWeight(wrWeight),
  .readySet(readySet), .readyClr(readyClr), .grantValid(grantValid),
  .grantIdx(grantIdx), .readyVec(readyVec), .revWeight(revWeight),
  .slotCnt(slotCnt)
);

// File: tb/test_wrr_cam_sched.sv
module test_wrr_cam_sched;
  import wrr_pkg::*;

  typedef struct packed {
    logic             v;
    logic [IDX_W-1:0] idx;
  } exp_t;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                wrEn = 1'b0;
  logic [IDX_W-1:0]    wrIdx = '0;
  logic [WEIGHT_W-1:0] wrWeight = '0;
  logic [NUM_VC-1:0]   readySet = '0;
  logic [NUM_VC-1:0]   readyClr = '0;
  logic                grantValid;
  logic [IDX_W-1:0]    grantIdx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // independent model
  logic [WEIGHT_W-1:0] mWeight [NUM_VC];
  logic [NUM_VC-1:0]   mReady;
  int                  mPtr;
  logic [WEIGHT_W-1:0] mCnt;
  exp_t                expQ [$];

  always #2.5 clk = ~clk;

  wrr_cam_sched i_wrr_cam_sched (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrWeight(wrWeight),
    .readySet(readySet), .readyClr(readyClr),
    .grantValid(grantValid), .grantIdx(grantIdx)
  );

  function automatic exp_t predict();
    exp_t e;
    int lvl;
    e = '0;
    lvl = -1;
    for (int k = WEIGHT_W-1; k >= 0; k--) if (!mCnt[k]) lvl = k;   // R2
    if (lvl >= 0) begin
      for (int off = 1; off <= NUM_VC; off++) begin                 // R5
        int c;
        c = (mPtr + off) % NUM_VC;
        if (!e.v && mReady[c] && mWeight[c][WEIGHT_W-1-lvl]) begin  // R3 R4
          e.v = 1'b1;
          e.idx = IDX_W'(c);
        end
      end
    end
    return e;
  endfunction

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver side: model predicts each slot and pushes the expected grant
  // monitor side: pops and compares to the design output
  always @(negedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_VC; i++) mWeight[i] = '0;
      mReady = '0;
      mPtr = NUM_VC - 1;
      mCnt = '0;
      expQ.delete();
    end else begin
      exp_t e, got;
      e = predict();
      expQ.push_back(e);
      got = expQ.pop_front();
      check("R4 R5 R6 grantValid", grantValid == got.v, grantValid, got.v);
      if (got.v)
        check("R3 R5 grantIdx", grantIdx == got.idx, grantIdx, got.idx);
      // state update for the closing edge
      if (wrEn) mWeight[wrIdx] = wrWeight;                          // R8
      for (int i = 0; i < NUM_VC; i++) begin                        // R7
        if (readySet[i]) mReady[i] = 1'b1;
        else if (e.v && e.idx == IDX_W'(i) && readyClr[i]) mReady[i] = 1'b0;
      end
      if (e.v) mPtr = int'(e.idx);
      mCnt = mCnt + WEIGHT_W'(1);                                   // R6
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic writeW(input int idx, input int w);
    wrEn = 1'b1; wrIdx = IDX_W'(idx); wrWeight = WEIGHT_W'(w);
    tick();
    wrEn = 1'b0;
  endtask

  task automatic pulseSet(input logic [NUM_VC-1:0] s, input logic [NUM_VC-1:0] c);
    readySet = s; readyClr = c;
    tick();
    readySet = '0; readyClr = '0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt0, cnt1, idles;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check("R9 reset grantValid", grantValid == 1'b0, grantValid, 0);
    tick();

    // R1 / R3: disjoint levels give exact shares
    writeW(0, 8);
    writeW(1, 4);
    pulseSet(8'b0000_0011, '0);
    tick();
    cnt0 = 0; cnt1 = 0; idles = 0;
    for (int n = 0; n < (1 << WEIGHT_W); n++) begin
      @(negedge clk);
      if (grantValid && grantIdx == 0) cnt0++;
      if (grantValid && grantIdx == 1) cnt1++;
      if (!grantValid) idles++;
    end
    check("R1 weight 8 share", cnt0 == 8, cnt0, 8);
    check("R1 weight 4 share", cnt1 == 4, cnt1, 4);
    check("R2 R6 idle slots", idles == 4, idles, 4);
    tick();

    // R5: rotation among three circuits on the same level
    writeW(2, 8);
    writeW(3, 8);
    pulseSet(8'b0000_1100, '0);
    repeat (40) tick();

    // R8: weight change mid-stream
    writeW(0, 1);
    repeat (20) tick();
    writeW(1, 15);
    repeat (20) tick();

    // R7: clear without grant is ignored, clear with grant drops ready
    readyClr = 8'b1111_1111;
    repeat (3) tick();
    readyClr = '0;
    repeat (10) tick();
    // R7: set and clear together keep the flag
    readySet = 8'b0000_1111; readyClr = 8'b0000_1111;
    repeat (12) tick();
    readySet = '0;
    readyClr = 8'b0000_1111;
    repeat (40) tick();
    readyClr = '0;
    cnt0 = 0;
    for (int n = 0; n < (1 << WEIGHT_W); n++) begin
      @(negedge clk);
      if (grantValid) cnt0++;
    end
    check("R6 R7 no grants once all queues drained", cnt0 == 0, cnt0, 0);
    tick();

    // R1 again with fresh weights and arrivals
    writeW(4, 6);
    writeW(5, 9);
    pulseSet(8'b0011_0000, '0);
    tick();
    cnt0 = 0; cnt1 = 0;
    for (int n = 0; n < (1 << WEIGHT_W); n++) begin
      @(negedge clk);
      if (grantValid && grantIdx == 4) cnt0++;
      if (grantValid && grantIdx == 5) cnt1++;
    end
    check("R1 weight 6 share", cnt0 == 6, cnt0, 6);
    check("R1 weight 9 share", cnt1 == 9, cnt1, 9);
    tick();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule